// File: doc/BRIEF.md
# Operand Address Former

This block forms the operand byte address for a 16-bit processor whose memory space is 128 KB. It takes a mode code, the contents of the selected register, the program counter, a 16-bit extension word and an access-size flag, and in the next cycle presents the 17-bit operand address. Alongside the address it presents the updated register value for the auto-stepping modes, a flag that says whether a memory operand cycle is needed, and a fault flag for word accesses that land on an odd byte. The program counter holds only the upper 16 of the 17 address bits, so the block also presents the word-aligned instruction fetch address.

The arithmetic is purely combinational. A single output register stage sits behind it, qualified by a valid bit that follows the input valid by one clock. When the input valid is low the result registers keep their previous contents and only the valid bit drops. A decoder turns the mode code into a small set of strobes; the datapath acts on those strobes.

Top module: `operand_addr_former`

## Requirements
- R1: One cycle after a cycle with `inValid` high, `outFetch` equals `pcVal` with a zero appended as bit 0.
- R2: `outValid` equals the value `inValid` had on the previous clock edge; all other outputs only change on edges where `inValid` is high.
- R3: Mode codes 0 (implied), 1 (immediate), 2 (register direct) and the unused codes 9 to 15 give `outAddr` = 0, `outMemAcc` = 0, `outWbEn` = 0 and `outFault` = 0, whatever the register holds.
- R4: Mode 3 (PC-relative) gives `outAddr` = ({`pcVal`, 0} + sign-extended `dispWord`) modulo 2^17.
- R5: Mode 4 (direct) gives `outAddr` = `dispWord` zero-extended to 17 bits.
- R6: Mode 5 (register indirect) gives `outAddr` = `regVal` zero-extended to 17 bits.
- R7: Mode 8 (indexed) gives `outAddr` = (zero-extended `regVal` + sign-extended `dispWord`) modulo 2^17, so the sum may cross into the upper 64 KB.
- R8: Mode 6 (predecrement) gives `outWbData` = (`regVal` − step) modulo 2^16 and uses that decremented value, zero-extended, as `outAddr`; step is 2 when `isWord` is 1 and 1 when it is 0.
- R9: Mode 7 (postincrement) gives `outAddr` = zero-extended `regVal` and `outWbData` = (`regVal` + step) modulo 2^16, with step as in R8.
- R10: In modes 3 to 8, a word access (`isWord` = 1) whose `outAddr` bit 0 is 1 sets `outFault`, clears `outMemAcc` and clears `outWbEn`; a byte access never faults. Otherwise those modes set `outMemAcc`, and modes 6 and 7 also set `outWbEn`.
- R11: While `rstN` is low, `outValid` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request qualifier for this cycle |
| mode | input | 4 | Addressing mode code |
| isWord | input | 1 | 1 = word access, 0 = byte access |
| regVal | input | 16 | Contents of the selected register |
| pcVal | input | 16 | Program counter (upper 16 address bits) |
| dispWord | input | 16 | Displacement or direct address word |
| outValid | output | 1 | Result registers hold a fresh result |
| outAddr | output | 17 | Operand byte address |
| outMemAcc | output | 1 | A memory operand cycle is required |
| outWbEn | output | 1 | Register must be written back |
| outWbData | output | 16 | Stepped register value |
| outFault | output | 1 | Word access at an odd address |
| outFetch | output | 17 | Word-aligned instruction fetch address |

## Verification
The register auto-step and the alignment fault can coincide: a predecrement or postincrement word access on a register holding an odd value steps the register and addresses an odd byte in the same cycle. The bench provokes this with odd register values in both stepping modes, and judges it by requiring the fault to be raised while both the write-back enable and the memory-access flag are held low, with the address still showing the odd byte. Byte-sized steps from odd values are run next to them to show that the same arithmetic without the size condition gives no fault and a normal write-back.

// File: rtl/oaf_pkg.sv
package oaf_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_IMPLIED  = 4'd0,
    MD_IMM      = 4'd1,
    MD_REGDIR   = 4'd2,
    MD_PCREL    = 4'd3,
    MD_DIRECT   = 4'd4,
    MD_INDIRECT = 4'd5,
    MD_PREDEC   = 4'd6,
    MD_POSTINC  = 4'd7,
    MD_INDEXED  = 4'd8
  } addrMode_e;

  typedef enum logic [1:0] {
    BASE_NONE   = 2'd0,
    BASE_REG    = 2'd1,
    BASE_PC     = 2'd2,
    BASE_DIRECT = 2'd3
  } baseSel_e;

  typedef struct packed {
    baseSel_e baseSel;
    logic     addDisp;
    logic     preDec;
    logic     postInc;
    logic     memAcc;
  } eaCtrl_t;

endpackage

// File: rtl/oaf_ctrl.sv
module oaf_ctrl
  import oaf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output eaCtrl_t           ctrl
);

  always_comb begin
    ctrl = '{baseSel: BASE_NONE, addDisp: 1'b0, preDec: 1'b0,
             postInc: 1'b0, memAcc: 1'b0};
    case (mode)
      MD_PCREL: begin
        ctrl.baseSel = BASE_PC;
        ctrl.addDisp = 1'b1;
        ctrl.memAcc  = 1'b1;
      end
      MD_DIRECT: begin
        ctrl.baseSel = BASE_DIRECT;
        ctrl.memAcc  = 1'b1;
      end
      MD_INDIRECT: begin
        ctrl.baseSel = BASE_REG;
        ctrl.memAcc  = 1'b1;
      end
      MD_PREDEC: begin
        ctrl.baseSel = BASE_REG;
        ctrl.preDec  = 1'b1;
        ctrl.memAcc  = 1'b1;
      end
      MD_POSTINC: begin
        ctrl.baseSel = BASE_REG;
        ctrl.postInc = 1'b1;
        ctrl.memAcc  = 1'b1;
      end
      MD_INDEXED: begin
        ctrl.baseSel = BASE_REG;
        ctrl.addDisp = 1'b1;
        ctrl.memAcc  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/oaf_datapath.sv
module oaf_datapath
  import oaf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  eaCtrl_t           ctrl,
  input  logic              isWord,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] pcVal,
  input  logic [DATA_W-1:0] dispWord,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outMemAcc,
  output logic              outWbEn,
  output logic [DATA_W-1:0] outWbData,
  output logic              outFault,
  output logic [ADDR_W-1:0] outFetch
);

  localparam int EXT_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] stepVal;
  logic [DATA_W-1:0] regDec;
  logic [DATA_W-1:0] regInc;
  logic [DATA_W-1:0] regEff;
  logic [ADDR_W-1:0] fetchAddr;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] offsetAddr;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] wbNext;
  logic              faultNext;

  assign stepVal   = isWord ? DATA_W'(2) : DATA_W'(1);
  assign regDec    = regVal - stepVal;
  assign regInc    = regVal + stepVal;
  assign regEff    = ctrl.preDec ? regDec : regVal;
  assign fetchAddr = {pcVal, {EXT_W{1'b0}}};

  always_comb begin
    case (ctrl.baseSel)
      BASE_REG:    baseAddr = {{EXT_W{1'b0}}, regEff};
      BASE_PC:     baseAddr = fetchAddr;
      BASE_DIRECT: baseAddr = {{EXT_W{1'b0}}, dispWord};
      default:     baseAddr = '0;
    endcase
  end

  assign offsetAddr = ctrl.addDisp ? {{EXT_W{dispWord[DATA_W-1]}}, dispWord} : '0;
  assign effAddr    = baseAddr + offsetAddr;

  always_comb begin
    if (ctrl.preDec)       wbNext = regDec;
    else if (ctrl.postInc) wbNext = regInc;
    else                   wbNext = regVal;
  end

  assign faultNext = ctrl.memAcc & isWord & effAddr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outAddr   <= '0;
      outMemAcc <= 1'b0;
      outWbEn   <= 1'b0;
      outWbData <= '0;
      outFault  <= 1'b0;
      outFetch  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outAddr   <= effAddr;
        outMemAcc <= ctrl.memAcc & ~faultNext;
        outWbEn   <= (ctrl.preDec | ctrl.postInc) & ~faultNext;
        outWbData <= wbNext;
        outFault  <= faultNext;
        outFetch  <= fetchAddr;
      end
    end
  end

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outFetch == {$past(pcVal), {EXT_W{1'b0}}}); // R1

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outAddr) && $stable(outWbData)); // R2

  AST_PREDEC_ADDR_IS_WB: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ctrl.preDec |=> outAddr[DATA_W-1:0] == outWbData); // R8

  AST_POSTINC_ORIG_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ctrl.postInc |=> outAddr == {{EXT_W{1'b0}}, $past(regVal)}); // R9

  AST_FAULT_BLOCKS_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFault |-> !outWbEn && !outMemAcc); // R10

  AST_FAULT_ODD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFault |-> outAddr[0]); // R10

  AST_NOMEM_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !ctrl.memAcc |=> !outFault && !outMemAcc && !outWbEn); // R3

endmodule

// File: rtl/operand_addr_former.sv
module operand_addr_former
  import oaf_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [MODE_W-1:0]     mode,
  input  logic                  isWord,
  input  logic [DATA_W-1:0]     regVal,
  input  logic [DATA_W-1:0]     pcVal,
  input  logic [DATA_W-1:0]     dispWord,
  output logic                  outValid,
  output logic [DATA_W:0]       outAddr,
  output logic                  outMemAcc,
  output logic                  outWbEn,
  output logic [DATA_W-1:0]     outWbData,
  output logic                  outFault,
  output logic [DATA_W:0]       outFetch
);

  localparam int ADDR_W = DATA_W + 1;

  eaCtrl_t ctrl;

  oaf_ctrl uCtrl (
    .mode (mode),
    .ctrl (ctrl)
  );

  oaf_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .ctrl      (ctrl),
    .isWord    (isWord),
    .regVal    (regVal),
    .pcVal     (pcVal),
    .dispWord  (dispWord),
    .outValid  (outValid),
    .outAddr   (outAddr),
    .outMemAcc (outMemAcc),
    .outWbEn   (outWbEn),
    .outWbData (outWbData),
    .outFault  (outFault),
    .outFetch  (outFetch)
  );

endmodule

// File: tb/operand_addr_former_test.sv
module operand_addr_former_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  typedef struct packed {
    logic [3:0]  mode;
    logic        word;
    logic [15:0] rv;
    logic [15:0] pc;
    logic [15:0] disp;
    logic [16:0] addr;
    logic        mem;
    logic        wbEn;
    logic [15:0] wb;
    logic        fault;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd0, 1'b1, 16'h1234, 16'h0100, 16'h0050, 17'h00000, 1'b0, 1'b0, 16'h0000, 1'b0},
    '{4'd1, 1'b1, 16'h1234, 16'h0100, 16'h0050, 17'h00000, 1'b0, 1'b0, 16'h0000, 1'b0},
    '{4'd2, 1'b1, 16'h1234, 16'h0100, 16'h0050, 17'h00000, 1'b0, 1'b0, 16'h0000, 1'b0},
    '{4'd3, 1'b1, 16'h0000, 16'h0100, 16'h0010, 17'h00210, 1'b1, 1'b0, 16'h0000, 1'b0},
    '{4'd3, 1'b1, 16'h0000, 16'h0001, 16'hFFFC, 17'h1FFFE, 1'b1, 1'b0, 16'h0000, 1'b0},
    '{4'd3, 1'b1, 16'h0000, 16'hFFFF, 16'h0004, 17'h00002, 1'b1, 1'b0, 16'h0000, 1'b0},
    '{4'd4, 1'b1, 16'h5555, 16'h0200, 16'h8000, 17'h08000, 1'b1, 1'b0, 16'h0000, 1'b0},
    '{4'd4, 1'b0, 16'h5555, 16'h0200, 16'h1235, 17'h01235, 1'b1, 1'b0, 16'h0000, 1'b0},
    '{4'd4, 1'b1, 16'h5555, 16'h0200, 16'h1235, 17'h01235, 1'b0, 1'b0, 16'h0000, 1'b1},
    '{4'd5, 1'b1, 16'hABCE, 16'h0300, 16'h7777, 17'h0ABCE, 1'b1, 1'b0, 16'h0000, 1'b0},
    '{4'd8, 1'b1, 16'h1000, 16'h0300, 16'hFFF0, 17'h00FF0, 1'b1, 1'b0, 16'h0000, 1'b0},
    '{4'd8, 1'b1, 16'hFFF0, 16'h0300, 16'h0020, 17'h10010, 1'b1, 1'b0, 16'h0000, 1'b0},
    '{4'd8, 1'b1, 16'h0004, 16'h0300, 16'hFFF0, 17'h1FFF4, 1'b1, 1'b0, 16'h0000, 1'b0},
    '{4'd6, 1'b1, 16'h2000, 16'h0400, 16'h0000, 17'h01FFE, 1'b1, 1'b1, 16'h1FFE, 1'b0},
    '{4'd6, 1'b0, 16'h2000, 16'h0400, 16'h0000, 17'h01FFF, 1'b1, 1'b1, 16'h1FFF, 1'b0},
    '{4'd6, 1'b1, 16'h0000, 16'h0400, 16'h0000, 17'h0FFFE, 1'b1, 1'b1, 16'hFFFE, 1'b0},
    '{4'd7, 1'b1, 16'h3000, 16'h0500, 16'h0000, 17'h03000, 1'b1, 1'b1, 16'h3002, 1'b0},
    '{4'd7, 1'b0, 16'hFFFF, 16'h0500, 16'h0000, 17'h0FFFF, 1'b1, 1'b1, 16'h0000, 1'b0},
    '{4'd7, 1'b1, 16'h3001, 16'h0500, 16'h0000, 17'h03001, 1'b0, 1'b0, 16'h0000, 1'b1},
    '{4'd6, 1'b1, 16'h3001, 16'h0500, 16'h0000, 17'h02FFF, 1'b0, 1'b0, 16'h0000, 1'b1},
    '{4'd12, 1'b1, 16'h3001, 16'h0600, 16'h1111, 17'h00000, 1'b0, 1'b0, 16'h0000, 1'b0},
    '{4'd2, 1'b1, 16'h0001, 16'h0600, 16'h0001, 17'h00000, 1'b0, 1'b0, 16'h0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  mode = '0;
  logic        isWord = 1'b0;
  logic [15:0] regVal = '0;
  logic [15:0] pcVal = '0;
  logic [15:0] dispWord = '0;
  logic        outValid;
  logic [16:0] outAddr;
  logic        outMemAcc;
  logic        outWbEn;
  logic [15:0] outWbData;
  logic        outFault;
  logic [16:0] outFetch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  operand_addr_former uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .isWord(isWord),
    .regVal(regVal), .pcVal(pcVal), .dispWord(dispWord),
    .outValid(outValid), .outAddr(outAddr), .outMemAcc(outMemAcc),
    .outWbEn(outWbEn), .outWbData(outWbData), .outFault(outFault),
    .outFetch(outFetch)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string addrReq(input logic [3:0] m);
    case (m)
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R8";
      4'd7: return "R9";
      4'd8: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic drive(input vec_t v, input bit vld);
    mode = v.mode; isWord = v.word; regVal = v.rv;
    pcVal = v.pc; dispWord = v.disp; inValid = vld;
  endtask

  task automatic checkRow(input vec_t v);
    string rq;
    rq = addrReq(v.mode);
    check(outValid === 1'b1, "R2", "outValid", 32'(outValid), 32'd1);
    check(outFetch === {v.pc, 1'b0}, "R1", "outFetch", 32'(outFetch), 32'({v.pc, 1'b0}));
    check(outAddr === v.addr, rq, "outAddr", 32'(outAddr), 32'(v.addr));
    check(outMemAcc === v.mem, v.fault ? "R10" : rq, "outMemAcc", 32'(outMemAcc), 32'(v.mem));
    check(outWbEn === v.wbEn, v.fault ? "R10" : rq, "outWbEn", 32'(outWbEn), 32'(v.wbEn));
    check(outFault === v.fault, "R10", "outFault", 32'(outFault), 32'(v.fault));
    if (v.wbEn)
      check(outWbData === v.wb, rq, "outWbData", 32'(outWbData), 32'(v.wb));
  endtask

  initial begin
    vec_t hold;
    repeat (2) @(negedge clk);
    // R11: reset state
    check(outValid === 1'b0, "R11", "outValid", 32'(outValid), 32'd0);
    check(outAddr === '0, "R11", "outAddr", 32'(outAddr), 32'd0);
    check(outFetch === '0, "R11", "outFetch", 32'(outFetch), 32'd0);
    check(outFault === 1'b0 && outMemAcc === 1'b0 && outWbEn === 1'b0, "R11",
          "flags", 32'({outFault, outMemAcc, outWbEn}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table walked back-to-back, one vector per cycle
    drive(VECS[0], 1'b1);
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      checkRow(VECS[i]);
      if (i + 1 < NVEC) drive(VECS[i+1], 1'b1);
    end

    // R2: invalid cycle drops valid and keeps results of the last request
    hold = VECS[13];
    drive(hold, 1'b1);
    @(negedge clk);
    checkRow(hold);
    drive(VECS[4], 1'b0);
    @(negedge clk);
    check(outValid === 1'b0, "R2", "outValid idle", 32'(outValid), 32'd0);
    check(outAddr === hold.addr, "R2", "outAddr held", 32'(outAddr), 32'(hold.addr));
    check(outWbData === hold.wb, "R2", "outWbData held", 32'(outWbData), 32'(hold.wb));
    check(outFetch === {hold.pc, 1'b0}, "R2", "outFetch held", 32'(outFetch), 32'({hold.pc, 1'b0}));

    // R11: reset mid-stream clears outputs
    drive(VECS[16], 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(outValid === 1'b0 && outAddr === '0 && outWbEn === 1'b0, "R11",
          "async clear", 32'({outValid, outWbEn, outAddr}), 32'd0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule